// File: doc/BRIEF.md
# Flash Mailbox Command Target

This block is the device end of a register mailbox that a host uses to reach the device's flash memory. A host performs single-dword reads and writes over a plain register bus. It fills a sixteen-dword data window, writes one command word and then polls that command word. When the low bit of the command word returns to zero, the command has finished. A status word then gives the opcode of the finished command and a result code.

The block runs four operations against a word-addressed memory port. A flash write copies window dwords into memory. A flash read copies memory dwords into the window. An authenticate-and-update operation reports success or an authentication failure. A power-cycle operation raises a one-cycle request pulse. Every command stays pending for a programmable number of clock cycles before it runs, which gives host polling a visible busy period. An opcode the block does not know, or a transfer that would run past the end of the modelled memory, finishes with an access error and does not touch memory.

Top module: `flash_mbox_target`

## Requirements
- R1: The data window sits at bus dword addresses WIN_BASE+1 to WIN_BASE+16 (0x3F to 0x4E by default). Window index i is at WIN_BASE+1+i, and a host write there reads back unchanged. The command word is at WIN_BASE+17 and the status word at WIN_BASE+18. Any other address reads as zero.
- R2: The command word fields are opcode [31:28], count [27:24], dword address [23:2], header-region flag [1] and request flag [0]. An idle block accepts a command only on a write with bit 0 set, and while busy the command word reads back exactly as written. A write with bit 0 clear leaves both the command word and the status word unchanged.
- R3: While the request flag is set, further writes to the command word are ignored. The command word keeps its value and the command already posted runs as posted.
- R4: The request flag stays set for at least OP_LATENCY clock cycles after a command is accepted. Then it clears by itself and leaves the other command bits as written.
- R5: Opcode 0x0 (flash write) copies count+1 dwords from window index 0 upward to memory starting at the dword address.
- R6: Opcode 0x2 (flash read) copies dwords from memory starting at the dword address into window index 0 upward. The number of dwords is the count field, and a count of 0 means 16. The window entries above the transfer keep their values, and the data is in place when the request flag clears.
- R7: The status word is {2'b00, response=1, 21'b0, opcode[3:0], result[3:0]}, and it is updated in the same cycle that the request flag clears. Result 0 means success, 1 means authentication failure and 2 means access error.
- R8: An opcode other than 0x0, 0x1, 0x2 or 0x4 completes with result 2. So does a flash read or write whose address plus dword count exceeds MEM_WORDS. In either case memory and the window are left unchanged.
- R9: Opcode 0x1 (authenticate-and-update) makes no memory access. It completes with result 1 if auth_fail is high at completion, and with result 0 otherwise.
- R10: Opcode 0x4 (power cycle) makes no memory access. It drives pwr_cycle high for exactly one cycle at completion and reports result 0.
- R11: After reset the command word, the status word and all window dwords read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | BUS_AW | Register bus dword address |
| bus_we | input | 1 | Register bus write strobe |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data, combinational from bus_addr |
| auth_fail | input | 1 | Verdict of the authentication check, sampled at completion |
| mem_addr | output | $clog2(MEM_WORDS) | Memory dword address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 32 | Memory read data, valid one cycle after mem_re |
| pwr_cycle | output | 1 | One-cycle power-cycle request |

## Verification
The assertions take the memory to return read data exactly one cycle after mem_re, and take auth_fail to hold steady while a command is pending. They also take the host to leave the data window alone while a flash read is filling it. The bench keeps to these conditions. Its memory model registers read data on the clock edge after the strobe, and it changes auth_fail only between commands. It writes window dwords only after polling shows the request flag clear. It does issue command-word writes during a busy period, because ignoring them is required behaviour.

// File: rtl/fmb_pkg.sv
// Package: shared constants, field helpers and state type for the flash
// mailbox target. Assumes a 32-bit register bus and a 16-dword window.
package fmb_pkg;

    localparam int DWORD_W    = 32;
    localparam int WIN_DWORDS = 16;
    localparam int LEN_W      = $clog2(WIN_DWORDS) + 1;
    localparam int ADDR_FLD_W = 22;

    localparam logic [3:0] OPC_WRITE = 4'h0;
    localparam logic [3:0] OPC_AUTH  = 4'h1;
    localparam logic [3:0] OPC_READ  = 4'h2;
    localparam logic [3:0] OPC_PWR   = 4'h4;

    localparam logic [3:0] RES_OK     = 4'h0;
    localparam logic [3:0] RES_AUTH   = 4'h1;
    localparam logic [3:0] RES_ACCESS = 4'h2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER,
        ST_DRAIN,
        ST_FIN
    } eng_state_e;

    // Opcode field of a command word.
    function automatic logic [3:0] cmd_opcode(input logic [DWORD_W-1:0] w);
        return w[31:28];
    endfunction

    // Count field of a command word.
    function automatic logic [3:0] cmd_count(input logic [DWORD_W-1:0] w);
        return w[27:24];
    endfunction

    // Dword address field of a command word.
    function automatic logic [ADDR_FLD_W-1:0] cmd_addr(input logic [DWORD_W-1:0] w);
        return w[23:2];
    endfunction

    // Status word built from an opcode and a result code.
    function automatic logic [DWORD_W-1:0] make_status(input logic [3:0] op,
                                                        input logic [3:0] res);
        return {2'b00, 1'b1, 21'd0, op, res};
    endfunction

endpackage

// File: rtl/fmb_window.sv
// Module: sixteen-dword data window with a host write port and an engine
// write port. The engine port wins when both ports hit the same index in one
// cycle. Assumes synchronous active-low reset; the contents are visible in
// parallel so that reads and engine fetches are combinational.
module fmb_window #(
    parameter int WORDS = fmb_pkg::WIN_DWORDS,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               host_we,
    input  logic [IDX_W-1:0]                   host_idx,
    input  logic [fmb_pkg::DWORD_W-1:0]        host_wdata,
    input  logic                               eng_we,
    input  logic [IDX_W-1:0]                   eng_idx,
    input  logic [fmb_pkg::DWORD_W-1:0]        eng_wdata,
    output logic [WORDS-1:0][fmb_pkg::DWORD_W-1:0] words
);

    // Store the window; the engine write follows the host write so it wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words <= '0;
        end else begin
            if (host_we) words[host_idx] <= host_wdata;
            if (eng_we)  words[eng_idx]  <= eng_wdata;
        end
    end

endmodule

// File: rtl/fmb_cmd_check.sv
// Module: combinational inspection of a command word. Works out the transfer
// length from the opcode-specific count encoding and flags unknown opcodes and
// transfers that run past the modelled memory. Assumes MEM_WORDS >= 1.
module fmb_cmd_check #(
    parameter int MEM_WORDS = 64
) (
    input  logic [fmb_pkg::DWORD_W-1:0] cmd_word,
    output logic [fmb_pkg::LEN_W-1:0]   xfer_len,
    output logic                        touches_mem,
    output logic                        is_read,
    output logic                        reject
);
    import fmb_pkg::*;

    localparam int END_W = ADDR_FLD_W + 2;

    logic [3:0]       op;
    logic [3:0]       cnt;
    logic [END_W-1:0] end_addr;
    logic             known;

    assign op  = cmd_opcode(cmd_word);
    assign cnt = cmd_count(cmd_word);

    // Decode the opcode and the count encoding that belongs to it.
    always_comb begin
        xfer_len    = '0;
        touches_mem = 1'b0;
        is_read     = 1'b0;
        known       = 1'b1;
        case (op)
            OPC_WRITE: begin
                xfer_len    = LEN_W'(cnt) + LEN_W'(1);
                touches_mem = 1'b1;
            end
            OPC_READ: begin
                xfer_len    = (cnt == 4'd0) ? LEN_W'(WIN_DWORDS) : LEN_W'(cnt);
                touches_mem = 1'b1;
                is_read     = 1'b1;
            end
            OPC_AUTH, OPC_PWR: known = 1'b1;
            default:           known = 1'b0;
        endcase
    end

    // Range check on the last dword touched plus one.
    assign end_addr = END_W'(cmd_addr(cmd_word)) + END_W'(xfer_len);
    assign reject   = !known || (touches_mem && (end_addr > END_W'(MEM_WORDS)));

endmodule

// File: rtl/fmb_engine.sv
// Module: command engine. Owns the command and status words, waits the
// programmed latency, moves dwords between window and memory, and posts the
// completion status. Assumes memory read data arrives one cycle after mem_re
// and that auth_fail is stable while a command is pending.
module fmb_engine #(
    parameter int MEM_WORDS  = 64,
    parameter int OP_LATENCY = 8,
    parameter int MEM_AW     = $clog2(MEM_WORDS)
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          post_we,
    input  logic [fmb_pkg::DWORD_W-1:0]                   post_data,
    input  logic                                          auth_fail,
    input  logic [fmb_pkg::WIN_DWORDS-1:0][fmb_pkg::DWORD_W-1:0] win_words,
    output logic                                          win_we,
    output logic [$clog2(fmb_pkg::WIN_DWORDS)-1:0]        win_idx,
    output logic [fmb_pkg::DWORD_W-1:0]                   win_wdata,
    output logic [MEM_AW-1:0]                             mem_addr,
    output logic                                          mem_we,
    output logic [fmb_pkg::DWORD_W-1:0]                   mem_wdata,
    output logic                                          mem_re,
    input  logic [fmb_pkg::DWORD_W-1:0]                   mem_rdata,
    output logic                                          pwr_cycle,
    output logic [fmb_pkg::DWORD_W-1:0]                   cmd_word,
    output logic [fmb_pkg::DWORD_W-1:0]                   status_word
);
    import fmb_pkg::*;

    localparam int WAIT_W = $clog2(OP_LATENCY + 1);
    localparam int IDX_W  = $clog2(WIN_DWORDS);

    eng_state_e          state_q;
    logic [DWORD_W-1:0]  cmd_q;
    logic [DWORD_W-1:0]  status_q;
    logic [3:0]          op_q;
    logic [MEM_AW-1:0]   base_q;
    logic [LEN_W-1:0]    len_q;
    logic                rd_q;
    logic                mem_q;
    logic                err_q;
    logic [WAIT_W-1:0]   wait_q;
    logic [LEN_W-1:0]    idx_q;
    logic                cap_vld_q;
    logic [IDX_W-1:0]    cap_idx_q;
    logic [3:0]          result;

    logic [LEN_W-1:0]    chk_len;
    logic                chk_mem;
    logic                chk_rd;
    logic                chk_reject;

    fmb_cmd_check #(.MEM_WORDS(MEM_WORDS)) u_check (
        .cmd_word    (post_data),
        .xfer_len    (chk_len),
        .touches_mem (chk_mem),
        .is_read     (chk_rd),
        .reject      (chk_reject)
    );

    // Result code chosen at completion.
    always_comb begin
        if (err_q)                 result = RES_ACCESS;
        else if (op_q == OPC_AUTH) result = auth_fail ? RES_AUTH : RES_OK;
        else                       result = RES_OK;
    end

    // Main sequencer: accept, wait, transfer, drain, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cmd_q    <= '0;
            status_q <= '0;
            op_q     <= '0;
            base_q   <= '0;
            len_q    <= '0;
            rd_q     <= 1'b0;
            mem_q    <= 1'b0;
            err_q    <= 1'b0;
            wait_q   <= '0;
            idx_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (post_we && post_data[0]) begin
                        cmd_q   <= post_data;
                        op_q    <= cmd_opcode(post_data);
                        base_q  <= post_data[2 +: MEM_AW];
                        len_q   <= chk_len;
                        rd_q    <= chk_rd;
                        mem_q   <= chk_mem;
                        err_q   <= chk_reject;
                        wait_q  <= '0;
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wait_q == WAIT_W'(OP_LATENCY - 1)) begin
                        idx_q   <= '0;
                        state_q <= (mem_q && !err_q) ? ST_XFER : ST_FIN;
                    end else begin
                        wait_q <= wait_q + WAIT_W'(1);
                    end
                end
                ST_XFER: begin
                    idx_q <= idx_q + LEN_W'(1);
                    if (idx_q == len_q - LEN_W'(1))
                        state_q <= rd_q ? ST_DRAIN : ST_FIN;
                end
                ST_DRAIN: state_q <= ST_FIN;
                ST_FIN: begin
                    status_q <= make_status(op_q, result);
                    cmd_q[0] <= 1'b0;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Read capture pipeline: data returns one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld_q <= 1'b0;
            cap_idx_q <= '0;
        end else begin
            cap_vld_q <= mem_re;
            cap_idx_q <= idx_q[IDX_W-1:0];
        end
    end

    // Memory and window side outputs.
    assign mem_re      = (state_q == ST_XFER) && rd_q;
    assign mem_we      = (state_q == ST_XFER) && !rd_q;
    assign mem_addr    = base_q + MEM_AW'(idx_q);
    assign mem_wdata   = win_words[idx_q[IDX_W-1:0]];
    assign win_we      = cap_vld_q;
    assign win_idx     = cap_idx_q;
    assign win_wdata   = mem_rdata;
    assign pwr_cycle   = (state_q == ST_FIN) && (op_q == OPC_PWR) && !err_q;
    assign cmd_word    = cmd_q;
    assign status_word = status_q;

    // Checker counter: cycles elapsed since the current command was accepted.
    logic [15:0] busy_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_cnt_q <= '0;
        else if (state_q == ST_IDLE)
            busy_cnt_q <= '0;
        else if (busy_cnt_q != 16'hFFFF)
            busy_cnt_q <= busy_cnt_q + 16'd1;
    end

    assert_cmd_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_FIN) |=> (cmd_q == $past(cmd_q)));

    assert_busy_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_q[0]) |-> (busy_cnt_q >= 16'(OP_LATENCY)));

    assert_status_stamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_q[0]) |-> (status_q[29] && status_q[7:4] == cmd_q[31:28]));

    assert_no_mem_on_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !(mem_we || mem_re));

    assert_xfer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (idx_q < len_q));

    assert_pwr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_cycle |=> (!pwr_cycle && !cmd_q[0]));

endmodule

// File: rtl/flash_mbox_target.sv
// Module: top of the flash mailbox target. Decodes the register bus into the
// data window, the command word and the status word, and joins the window to
// the command engine. Assumes single-cycle bus writes and a combinational
// read path; WIN_BASE + 18 must fit in BUS_AW bits.
module flash_mbox_target #(
    parameter int BUS_AW     = 8,
    parameter int WIN_BASE   = 'h3E,
    parameter int MEM_WORDS  = 64,
    parameter int OP_LATENCY = 8,
    parameter int MEM_AW     = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              auth_fail,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_we,
    output logic [31:0]       mem_wdata,
    output logic              mem_re,
    input  logic [31:0]       mem_rdata,
    output logic              pwr_cycle
);
    import fmb_pkg::*;

    localparam int IDX_W   = $clog2(WIN_DWORDS);
    localparam int DATA_LO = WIN_BASE + 1;
    localparam int DATA_HI = WIN_BASE + WIN_DWORDS;
    localparam int CMD_AT  = WIN_BASE + WIN_DWORDS + 1;
    localparam int STAT_AT = WIN_BASE + WIN_DWORDS + 2;

    logic                                     hit_data;
    logic                                     hit_cmd;
    logic                                     hit_stat;
    logic [IDX_W-1:0]                         data_idx;
    logic [WIN_DWORDS-1:0][DWORD_W-1:0]       win_words;
    logic                                     eng_win_we;
    logic [IDX_W-1:0]                         eng_win_idx;
    logic [DWORD_W-1:0]                       eng_win_wdata;
    logic [DWORD_W-1:0]                       cmd_word;
    logic [DWORD_W-1:0]                       status_word;
    logic [BUS_AW-1:0]                        data_off;

    // Address decode of the register window.
    assign hit_data = (bus_addr >= BUS_AW'(DATA_LO)) && (bus_addr <= BUS_AW'(DATA_HI));
    assign hit_cmd  = (bus_addr == BUS_AW'(CMD_AT));
    assign hit_stat = (bus_addr == BUS_AW'(STAT_AT));
    assign data_off = bus_addr - BUS_AW'(DATA_LO);
    assign data_idx = data_off[IDX_W-1:0];

    fmb_window #(.WORDS(WIN_DWORDS)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (bus_we && hit_data),
        .host_idx   (data_idx),
        .host_wdata (bus_wdata),
        .eng_we     (eng_win_we),
        .eng_idx    (eng_win_idx),
        .eng_wdata  (eng_win_wdata),
        .words      (win_words)
    );

    fmb_engine #(
        .MEM_WORDS  (MEM_WORDS),
        .OP_LATENCY (OP_LATENCY)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .post_we     (bus_we && hit_cmd),
        .post_data   (bus_wdata),
        .auth_fail   (auth_fail),
        .win_words   (win_words),
        .win_we      (eng_win_we),
        .win_idx     (eng_win_idx),
        .win_wdata   (eng_win_wdata),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .mem_re      (mem_re),
        .mem_rdata   (mem_rdata),
        .pwr_cycle   (pwr_cycle),
        .cmd_word    (cmd_word),
        .status_word (status_word)
    );

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        if (hit_data)      bus_rdata = win_words[data_idx];
        else if (hit_cmd)  bus_rdata = cmd_word;
        else if (hit_stat) bus_rdata = status_word;
        else               bus_rdata = '0;
    end

    assert_rd_unmapped_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_data || hit_cmd || hit_stat) |-> (bus_rdata == 32'd0));

endmodule

// File: tb/tb_flash_mbox_target.sv
module tb_flash_mbox_target;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 'h3E;
    localparam int MEMW       = 64;
    localparam int LAT        = 5;
    localparam int CMD_A      = BASE + 17;
    localparam int STAT_A     = BASE + 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        auth_fail = 1'b0;
    logic [5:0]  mem_addr;
    logic        mem_we;
    logic [31:0] mem_wdata;
    logic        mem_re;
    logic [31:0] mem_rdata;
    logic        pwr_cycle;

    int n_checks = 0;
    int n_fails  = 0;
    int pwr_seen = 0;
    int cycles   = 0;

    logic [31:0] mem     [MEMW];
    logic [31:0] exp_mem [MEMW];
    logic [31:0] exp_win [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_mbox_target #(
        .BUS_AW(8), .WIN_BASE(BASE), .MEM_WORDS(MEMW), .OP_LATENCY(LAT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .auth_fail(auth_fail),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .pwr_cycle(pwr_cycle)
    );

    // Memory model: write on the edge, read data registered one cycle later.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (pwr_cycle) pwr_seen <= pwr_seen + 1;
        cycles <= cycles + 1;
    end

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog.
    initial begin
        wait (cycles > 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run hung, got %0d cycles, expected completion", cycles);
        summary_and_end();
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, got, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = 8'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_rd(input int a, output logic [31:0] d);
        bus_addr = 8'(a);
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] pat(input int seed, input int i);
        return 32'h5A000000 ^ (32'(seed) << 12) ^ (32'(i) * 32'h00010101);
    endfunction

    function automatic logic [31:0] mk_cmd(input logic [3:0] op, input int cnt, input int addr);
        return {op, 4'(cnt), 22'(addr), 1'b0, 1'b1};
    endfunction

    task automatic fill_window(input int seed);
        for (int i = 0; i < 16; i++) begin
            bus_wr(BASE + 1 + i, pat(seed, i));
            exp_win[i] = pat(seed, i);
        end
    endtask

    // Post a command and poll the request flag; returns busy poll count.
    task automatic run_cmd(input logic [31:0] cmd, input bit interfere, output int polls);
        logic [31:0] rd;
        polls = 0;
        bus_wr(CMD_A, cmd);
        bus_rd(CMD_A, rd);
        check("R2", "command readback while busy", rd, cmd);
        if (interfere) begin
            bus_wr(CMD_A, 32'hF3FF_FFFD);
            bus_wr(CMD_A, 32'h4000_0001);
            bus_rd(CMD_A, rd);
            check("R3", "command word after writes during busy", rd, cmd);
        end
        for (int k = 0; k < 1000; k++) begin
            bus_rd(CMD_A, rd);
            if (!rd[0]) break;
            polls++;
            @(negedge clk);
        end
        bus_rd(CMD_A, rd);
        check("R4", "request flag cleared, other bits kept", rd, cmd & 32'hFFFF_FFFE);
    endtask

    task automatic check_mem(input string req);
        int bad = -1;
        for (int i = 0; i < MEMW; i++)
            if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
        n_checks++;
        if (bad >= 0) begin
            n_fails++;
            $display("FAIL %s memory dword %0d: actual %08h expected %08h",
                     req, bad, mem[bad], exp_mem[bad]);
        end
    endtask

    task automatic check_window(input string req);
        logic [31:0] rd;
        for (int i = 0; i < 16; i++) begin
            bus_rd(BASE + 1 + i, rd);
            check(req, $sformatf("window %0d", i), rd, exp_win[i]);
        end
    endtask

    task automatic check_status(input string req, input logic [3:0] op, input logic [3:0] res);
        logic [31:0] rd;
        bus_rd(STAT_A, rd);
        check(req, "status word", rd, {2'b00, 1'b1, 21'd0, op, res});
    endtask

    initial begin
        logic [31:0] rd;
        int polls;
        int n;
        int a;
        for (int i = 0; i < MEMW; i++) begin
            mem[i]     = 32'hC0DE0000 + 32'(i);
            exp_mem[i] = 32'hC0DE0000 + 32'(i);
        end
        for (int i = 0; i < 16; i++) exp_win[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state.
        bus_rd(CMD_A, rd);  check("R11", "command after reset", rd, 32'h0);
        bus_rd(STAT_A, rd); check("R11", "status after reset", rd, 32'h0);
        check_window("R11");

        // R1: window map and unmapped addresses.
        fill_window(1);
        check_window("R1");
        bus_rd(BASE, rd);      check("R1", "address below window", rd, 32'h0);
        bus_rd(BASE + 19, rd); check("R1", "address above window", rd, 32'h0);
        bus_rd(0, rd);         check("R1", "address zero", rd, 32'h0);

        // R2: write without request flag while idle is ignored.
        bus_wr(CMD_A, 32'h2100_0100);
        repeat (LAT + 3) @(negedge clk);
        bus_rd(CMD_A, rd);  check("R2", "command after write with bit0 clear", rd, 32'h0);
        bus_rd(STAT_A, rd); check("R2", "status after write with bit0 clear", rd, 32'h0);
        check_mem("R2");

        // R5: flash write sweep over every count value.
        for (int c = 0; c < 16; c++) begin
            fill_window(10 + c);
            n = c + 1;
            a = 2 * c;
            run_cmd(mk_cmd(4'h0, c, a), 1'b0, polls);
            check("R4", "busy polls at least latency", 32'(polls >= LAT), 32'd1);
            for (int i = 0; i < n; i++) exp_mem[a + i] = exp_win[i];
            check_mem("R5");
            check_status("R7", 4'h0, 4'h0);
        end

        // R6: flash read sweep over every count value.
        for (int c = 0; c < 16; c++) begin
            fill_window(40 + c);
            n = (c == 0) ? 16 : c;
            a = 48 - c;
            run_cmd(mk_cmd(4'h2, c, a), 1'b0, polls);
            for (int i = 0; i < n; i++) exp_win[i] = exp_mem[a + i];
            check_window("R6");
            check_mem("R6");
            check_status("R7", 4'h2, 4'h0);
        end

        // R5 boundary: write ending exactly at the last dword.
        fill_window(70);
        run_cmd(mk_cmd(4'h0, 3, 60), 1'b0, polls);
        for (int i = 0; i < 4; i++) exp_mem[60 + i] = exp_win[i];
        check_mem("R5");
        check_status("R7", 4'h0, 4'h0);

        // R8: write running one past the end.
        fill_window(71);
        run_cmd(mk_cmd(4'h0, 3, 61), 1'b0, polls);
        check_mem("R8");
        check_status("R8", 4'h0, 4'h2);

        // R8: full-window read running one past the end.
        fill_window(72);
        run_cmd(mk_cmd(4'h2, 0, 49), 1'b0, polls);
        check_window("R8");
        check_status("R8", 4'h2, 4'h2);

        // R8: address far above memory.
        run_cmd(mk_cmd(4'h2, 1, 'h3FFFFF), 1'b0, polls);
        check_window("R8");
        check_status("R8", 4'h2, 4'h2);

        // R8: unknown opcodes.
        for (int o = 3; o < 16; o++) begin
            if (o == 4) continue;
            run_cmd(mk_cmd(4'(o), 0, 0), 1'b0, polls);
            check_mem("R8");
            check_status("R8", 4'(o), 4'h2);
        end
        check_window("R8");

        // R9: authenticate, pass and fail.
        auth_fail = 1'b0;
        run_cmd(mk_cmd(4'h1, 0, 0), 1'b0, polls);
        check_status("R9", 4'h1, 4'h0);
        auth_fail = 1'b1;
        run_cmd(mk_cmd(4'h1, 0, 0), 1'b0, polls);
        check_status("R9", 4'h1, 4'h1);
        auth_fail = 1'b0;
        check_mem("R9");

        // R10: power cycle pulse.
        pwr_seen = 0;
        run_cmd(mk_cmd(4'h4, 0, 0), 1'b0, polls);
        @(negedge clk);
        check("R10", "power-cycle pulse count", 32'(pwr_seen), 32'd1);
        check_status("R10", 4'h4, 4'h0);
        check_mem("R10");

        // R3: command writes during busy are ignored; posted write runs.
        fill_window(90);
        pwr_seen = 0;
        run_cmd(mk_cmd(4'h0, 1, 20), 1'b1, polls);
        for (int i = 0; i < 2; i++) exp_mem[20 + i] = exp_win[i];
        check_mem("R3");
        check_status("R3", 4'h0, 4'h0);
        check("R3", "no power-cycle from ignored write", 32'(pwr_seen), 32'd0);

        summary_and_end();
    end

endmodule